// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block connects a clocked request port to an external asynchronous static RAM of 262,144 sixteen-bit words with active-low strobes: chip select, write strobe, output enable, and one enable per byte lane. A requester presents an address, a write flag, write data and a two-bit lane mask under a valid/ready handshake. The controller then drives the strobes through a fixed sequence. Each phase lasts a parameterised number of clocks. The integrator sets each count as the ceiling of the memory's nanosecond minimum divided by the clock period. Read data comes back registered with a one-cycle valid pulse.

The shared data pins are split into an output word, a drive enable and an input word. The controller never drives those pins while the memory could be driving them. After every read it leaves at least one clock with nothing on the bus.

The controller is a single state machine:
- States: `ST_IDLE`, `ST_WR_SETUP`, `ST_WR_PULSE`, `ST_WR_HOLD`, `ST_RD_ACCESS`, `ST_RD_TURN` and `ST_NULL`.
- Transitions out of `ST_IDLE`:
  - IDLE→NULL on an accepted request with an empty mask.
  - IDLE→WR_SETUP on an accepted write.
  - IDLE→RD_ACCESS on an accepted read.
- Write path: WR_SETUP→WR_PULSE, then WR_PULSE→WR_HOLD, then WR_HOLD→IDLE, each when the phase timer expires.
- Read path: RD_ACCESS→RD_TURN when the timer expires, then RD_TURN→IDLE when the timer expires.
- NULL→IDLE always after one clock.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and when idle after reset, every strobe (chip select, write strobe, output enable, both lane enables) is high. The bus drive enable is low, `rd_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only in the idle state. It goes low at the clock edge that accepts a request and stays low until that request's sequence has completed. While it is high, no strobe is low and the bus is not driven.
- R3: An accepted write with a non-zero mask runs three phases. First, SETUP_CYC clocks with chip select low, write strobe high and the bus driven. Then WE_CYC clocks with the write strobe low. Then HOLD_CYC clocks with the write strobe high again. The output enable stays high in all three phases.
- R4: For the whole of a write, the address, the driven data and the lane enables stay constant. Chip select stays low.
- R5: An accepted read with a non-zero mask holds chip select and output enable low, the write strobe high and the bus undriven for RD_CYC clocks.
- R6: Lane enable bit 0 (`sram_be_n[0]`) governs data bits 7:0, and bit 1 governs bits 15:8. A lane is enabled (low) exactly when the matching `req_mask` bit is 1.
- R7: Read data is sampled from `sram_dq_in` on the last access clock. `rd_valid` pulses high for exactly one clock right after it. Any lane whose mask bit is 0 reads back as zero.
- R8: After a read, TURN_CYC clocks follow with every strobe high, the bus undriven and `req_ready` low. Only then can a new request be accepted.
- R9: Output enable and write strobe are never low together. The bus is never driven while output enable is low.
- R10: A request whose mask is zero takes one busy clock with no strobe and no bus drive. A zero-mask write leaves memory unchanged. A zero-mask read pulses `rd_valid` with all-zero data.
- R11: A masked write changes only its enabled lanes. A later full read returns the new bytes in those lanes and the earlier bytes in the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| rd_valid | output | 1 | One-clock pulse with returned read data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 18 | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | 1 = controller drives the data pins |
| sram_dq_in | input | 16 | Data from the memory pins |

## Verification
The hardest situation to reach is a read followed immediately by a write. This is the only path where a missing turnaround clock would put the controller's drivers against the memory's still-active outputs. It can only arise if the requester has the next request waiting the moment `req_ready` returns. The stimulus therefore queues every request as soon as ready is seen, and it alternates write and read back to back. Zero-mask reads are sent back to back as well. In that case the new request is accepted in the same idle clock that carries the previous `rd_valid` pulse.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_PULSE  = 3'd2,
        ST_WR_HOLD   = 3'd3,
        ST_RD_ACCESS = 3'd4,
        ST_RD_TURN   = 3'd5,
        ST_NULL      = 3'd6
    } ctl_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic [LANES-1:0]         lane_sel,
    input  logic [LANES*LANE_W-1:0]  pins_in,
    output logic [LANES*LANE_W-1:0]  word_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_out[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                word_out[g*LANE_W +: LANE_W] <= lane_sel[g] ? pins_in[g*LANE_W +: LANE_W]
                                                            : '0;
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int LANE_W    = 8,
    parameter int LANES     = 2,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 3,
    parameter int HOLD_CYC  = 1,
    parameter int RD_CYC    = 4,
    parameter int TURN_CYC  = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [LANES*LANE_W-1:0]     req_wdata,
    input  logic [LANES-1:0]            req_mask,
    output logic                        rd_valid,
    output logic [LANES*LANE_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]           sram_addr,
    output logic                        sram_ce_n,
    output logic                        sram_we_n,
    output logic                        sram_oe_n,
    output logic [LANES-1:0]            sram_be_n,
    output logic [LANES*LANE_W-1:0]     sram_dq_out,
    output logic                        sram_dq_oe,
    input  logic [LANES*LANE_W-1:0]     sram_dq_in
);

    localparam int DATA_W  = LANES * LANE_W;
    localparam int MAX_CYC = max_of(max_of(max_of(SETUP_CYC, WE_CYC), max_of(HOLD_CYC, RD_CYC)),
                                    TURN_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_e        state_q, state_d;
    logic              accept;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              cap_now;
    logic              lat_write;
    logic [LANES-1:0]  lat_mask;
    logic [LANES-1:0]  mask_src;
    logic              nxt_sel, nxt_we, nxt_oe, nxt_drv;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign mask_src = accept ? req_mask : lat_mask;

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_lane_capture #(.LANES(LANES), .LANE_W(LANE_W)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cap_now),
        .lane_sel (lat_mask),
        .pins_in  (sram_dq_in),
        .word_out (rd_data)
    );

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_now  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_mask == '0) begin
                        state_d = ST_NULL;
                    end else if (req_write) begin
                        state_d  = ST_WR_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WE_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    cap_now  = 1'b1;
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_NULL: begin
                cap_now = !lat_write;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lat_write <= 1'b0;
            lat_mask  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lat_write <= req_write;
                lat_mask  <= req_mask;
            end
        end
    end

    // Strobe decode of the state being entered
    always_comb begin
        nxt_sel = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                  (state_d == ST_WR_HOLD)  || (state_d == ST_RD_ACCESS);
        nxt_we  = (state_d == ST_WR_PULSE);
        nxt_oe  = (state_d == ST_RD_ACCESS);
        nxt_drv = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                  (state_d == ST_WR_HOLD);
    end

    // Registered outputs, glitch-free toward the memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_ready   <= 1'b1;
            rd_valid    <= 1'b0;
            sram_ce_n   <= 1'b1;
            sram_we_n   <= 1'b1;
            sram_oe_n   <= 1'b1;
            sram_be_n   <= '1;
            sram_dq_oe  <= 1'b0;
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else begin
            req_ready  <= (state_d == ST_IDLE);
            rd_valid   <= cap_now;
            sram_ce_n  <= !nxt_sel;
            sram_we_n  <= !nxt_we;
            sram_oe_n  <= !nxt_oe;
            sram_dq_oe <= nxt_drv;
            sram_be_n  <= ~(mask_src & {LANES{nxt_sel}});
            if (accept) begin
                sram_addr   <= req_addr;
                sram_dq_out <= req_wdata;
            end
        end
    end

    // R9
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    // R9
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && sram_dq_oe));

    // R3
    we_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (!sram_ce_n && $past(!sram_ce_n) && sram_dq_oe));

    // R4
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |->
            ($stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_be_n) && !sram_ce_n));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

    localparam int SETUP_CYC = 1;
    localparam int WE_CYC    = 3;
    localparam int HOLD_CYC  = 1;
    localparam int RD_CYC    = 4;
    localparam int TURN_CYC  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out;
    logic [15:0] sram_dq_in;

    always #10 clk = ~clk;

    sram_lane_ctrl #(
        .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC), .HOLD_CYC(HOLD_CYC),
        .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)
    ) i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // ---------------- behavioural memory on the pins ----------------
    bit [15:0] pin_mem [int];
    bit        prev_we = 1'b1;

    function automatic bit [15:0] pin_word(input int a);
        return pin_mem.exists(a) ? pin_mem[a] : 16'h0000;
    endfunction

    always_comb begin
        sram_dq_in = 16'hA5C3;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            if (!sram_be_n[0]) sram_dq_in[7:0]  = pin_word(int'(sram_addr))[7:0];
            if (!sram_be_n[1]) sram_dq_in[15:8] = pin_word(int'(sram_addr))[15:8];
        end
    end

    always @(negedge clk) begin
        if (prev_we == 1'b0 && sram_we_n == 1'b1 && !sram_ce_n) begin
            bit [15:0] w;
            w = pin_word(int'(sram_addr));
            if (!sram_be_n[0]) w[7:0]  = sram_dq_out[7:0];
            if (!sram_be_n[1]) w[15:8] = sram_dq_out[15:8];
            pin_mem[int'(sram_addr)] = w;
        end
        prev_we = sram_we_n;
    end

    // ---------------- reference model ----------------
    typedef struct packed {
        bit        rdy;
        bit        ce_n;
        bit        we_n;
        bit        oe_n;
        bit [1:0]  be_n;
        bit        drv;
        bit [17:0] addr;
        bit [15:0] wd;
        bit        vld;
        bit [15:0] rdat;
    } exp_t;

    exp_t      expq[$];
    string     tagq[$];
    bit [15:0] shadow [int];
    int        vectors = 0;
    int        fails = 0;
    bit        checking = 1'b0;
    bit        finished = 1'b0;

    function automatic exp_t quiet_vec(input bit rdy);
        exp_t v;
        v = '0;
        v.rdy = rdy; v.ce_n = 1; v.we_n = 1; v.oe_n = 1; v.be_n = 2'b11;
        return v;
    endfunction

    function automatic bit [15:0] shadow_word(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    task automatic push_req(input bit wr, input bit [17:0] a, input bit [15:0] d,
                            input bit [1:0] m, input string rtag);
        exp_t v;
        if (m == 2'b00) begin
            v = quiet_vec(0);
            expq.push_back(v); tagq.push_back("R10");
            if (!wr) begin
                v = quiet_vec(1); v.vld = 1; v.rdat = 16'h0000;
                expq.push_back(v); tagq.push_back("R10");
            end
        end else if (wr) begin
            v = quiet_vec(0);
            v.ce_n = 0; v.be_n = ~m; v.drv = 1; v.addr = a; v.wd = d;
            for (int i = 0; i < SETUP_CYC; i++) begin expq.push_back(v); tagq.push_back("R3"); end
            v.we_n = 0;
            for (int i = 0; i < WE_CYC; i++) begin expq.push_back(v); tagq.push_back("R3"); end
            v.we_n = 1;
            for (int i = 0; i < HOLD_CYC; i++) begin expq.push_back(v); tagq.push_back("R4"); end
            begin
                bit [15:0] w;
                w = shadow_word(int'(a));
                if (m[0]) w[7:0]  = d[7:0];
                if (m[1]) w[15:8] = d[15:8];
                shadow[int'(a)] = w;
            end
        end else begin
            v = quiet_vec(0);
            v.ce_n = 0; v.oe_n = 0; v.be_n = ~m; v.addr = a;
            for (int i = 0; i < RD_CYC; i++) begin expq.push_back(v); tagq.push_back("R5"); end
            for (int i = 0; i < TURN_CYC; i++) begin
                v = quiet_vec(0);
                if (i == 0) begin
                    v.vld = 1;
                    v.rdat = shadow_word(int'(a)) & {{8{m[1]}}, {8{m[0]}}};
                    expq.push_back(v); tagq.push_back(rtag);
                end else begin
                    expq.push_back(v); tagq.push_back("R8");
                end
            end
        end
    endtask

    task automatic compare(input exp_t e, input string t);
        bit bad;
        bad = 0;
        vectors++;
        if (req_ready !== e.rdy || sram_ce_n !== e.ce_n || sram_we_n !== e.we_n ||
            sram_oe_n !== e.oe_n || sram_be_n !== e.be_n || sram_dq_oe !== e.drv ||
            rd_valid !== e.vld) begin
            bad = 1;
            $display("FAIL %s t=%0t strobes rdy/ce/we/oe/be/drv/vld actual %b%b%b%b%b%b%b expected %b%b%b%b%b%b%b",
                     t, $time, req_ready, sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe, rd_valid,
                     e.rdy, e.ce_n, e.we_n, e.oe_n, e.be_n, e.drv, e.vld);
        end
        if (!e.ce_n && sram_addr !== e.addr) begin
            bad = 1;
            $display("FAIL %s t=%0t addr actual %h expected %h", t, $time, sram_addr, e.addr);
        end
        if (e.drv && sram_dq_out !== e.wd) begin
            bad = 1;
            $display("FAIL %s t=%0t wdata actual %h expected %h", t, $time, sram_dq_out, e.wd);
        end
        if (e.vld && rd_data !== e.rdat) begin
            bad = 1;
            $display("FAIL %s t=%0t rd_data actual %h expected %h", t, $time, rd_data, e.rdat);
        end
        if (!sram_oe_n && (!sram_we_n || sram_dq_oe)) begin
            bad = 1;
            $display("FAIL R9 t=%0t oe/we/drv actual %b%b%b expected no overlap",
                     $time, sram_oe_n, sram_we_n, sram_dq_oe);
        end
        if (bad) fails++;
    endtask

    always @(negedge clk) begin
        if (checking) begin
            if (expq.size() != 0) compare(expq.pop_front(), tagq.pop_front());
            else                  compare(quiet_vec(1), "R2");
        end
    end

    task automatic issue(input bit wr, input bit [17:0] a, input bit [15:0] d,
                         input bit [1:0] m, input string rtag);
        @(negedge clk); #1;
        while (!req_ready) begin @(negedge clk); #1; end
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        push_req(wr, a, d, m, rtag);
        @(posedge clk); #1;
        req_valid = 0;
        req_addr  = ~a;
        req_wdata = ~d;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog t=%0t actual hung expected completion", $time);
        wrap_up();
    end

    initial begin
        // R1: idle outputs while reset is held
        repeat (3) begin
            @(negedge clk);
            compare(quiet_vec(1), "R1");
        end
        rst_n = 1;
        checking = 1;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R7: full write and read back
        issue(1, 18'h00010, 16'h1234, 2'b11, "R7");
        issue(0, 18'h00010, 16'h0000, 2'b11, "R7");
        // R6 R11: low lane only, then full read
        issue(1, 18'h00010, 16'hBEEF, 2'b01, "R6");
        issue(0, 18'h00010, 16'h0000, 2'b11, "R11");
        // R6 R11: high lane only, then per-lane reads (disabled lane zero)
        issue(1, 18'h00010, 16'h5600, 2'b10, "R6");
        issue(0, 18'h00010, 16'h0000, 2'b10, "R7");
        issue(0, 18'h00010, 16'h0000, 2'b01, "R7");
        // R10: zero-mask write and back-to-back zero-mask reads
        issue(1, 18'h00010, 16'hFFFF, 2'b00, "R10");
        issue(0, 18'h00010, 16'h0000, 2'b00, "R10");
        issue(0, 18'h00010, 16'h0000, 2'b00, "R10");
        issue(0, 18'h00010, 16'h0000, 2'b11, "R10");
        // R8: read immediately followed by write, address extremes
        issue(1, 18'h00000, 16'hC001, 2'b11, "R3");
        issue(0, 18'h00000, 16'h0000, 2'b11, "R8");
        issue(1, 18'h3FFFF, 16'hD00D, 2'b11, "R8");
        issue(0, 18'h3FFFF, 16'h0000, 2'b11, "R8");
        issue(0, 18'h00000, 16'h0000, 2'b11, "R7");
        // R11: sweep of patterns and masks
        for (int k = 0; k < 12; k++) begin
            bit [17:0] a;
            bit [15:0] d;
            a = 18'(k * 4099 + 7);
            d = 16'(k * 16'h1357 + 16'h0F0F);
            issue(1, a, d, 2'(k % 4), "R11");
            issue(0, a, 16'h0000, 2'b11, "R11");
        end
        drain();
        wrap_up();
    end

endmodule